// File: doc/BRIEF.md
# Four-Way Victim / Next-Victim Replacement Controller

This block holds the replacement state of a single set in a four-way set-associative cache. It does not keep a full recency order. Instead, every way carries two role flags. One flag says the way will be evicted on the next miss (the victim). The other says it is queued to become the victim after that (the next victim). The set therefore holds eight bits of replacement state in total. At all times after reset, exactly one way holds each role, and the two roles sit on different ways.

The surrounding cache signals each lookup on the access strobe, together with a hit flag and, on a hit, the index of the way that matched. The controller updates its role flags on the clock edge that takes the access. It presents the current victim index, and the current next-victim index, combinationally from the stored flags.

When a new next victim must be named, exactly two ways hold neither role. One of them is picked with a bit from a free-running 8-bit linear feedback shift register (LFSR) inside the block.

Top module: `vnv_repl_set`

## Requirements
- R1: While reset is asserted and right after it, `victim_way` is 0, `next_way` is 1, and the LFSR holds the seed 8'hA5.
- R2: At every clock after reset, exactly one way holds the victim role and exactly one different way holds the next-victim role.
- R3: `victim_way` and `next_way` are decoded combinationally from the stored role flags. The result of an access is visible right after the clock edge that samples it.
- R4: On a miss (`acc_valid`=1, `acc_hit`=0), the old next victim becomes the victim. A new next victim is taken from the two ways that held neither role.
- R5: A hit to the victim way behaves exactly like a miss: promotion of the next victim, and a fresh pick of the next victim.
- R6: On a hit to the next-victim way, the victim stays put. The new next victim is taken from the two ways other than the victim and the old next victim.
- R7: A hit to a way holding neither role leaves both roles unchanged.
- R8: While `acc_valid` is 0, `acc_hit` and `acc_way` have no effect on the roles.
- R9: The tie-break between the two candidate ways works as follows:
  - The lower-indexed candidate is taken when LFSR bit 0 is 0, and the higher-indexed one when it is 1.
  - The LFSR shifts left every clock out of reset, whether or not an access occurs.
  - Its new bit 0 is the XOR of bits 7, 5, 4 and 3.
- R10: On a miss, the value on `acc_way` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A lookup of this set happens this cycle |
| acc_hit | input | 1 | The lookup hit (meaningful only with acc_valid) |
| acc_way | input | 2 | Way that hit (meaningful only on a hit) |
| victim_way | output | 2 | Way to evict and refill on the next miss |
| next_way | output | 2 | Way queued to become the victim next |

## Verification
The controller is driven with several kinds of traffic:
- Idle cycles that carry junk hit and way values. These show the strobe gates every update (R8).
- Misses with assorted `acc_way` values. These separate promotion from any dependence on the way index (R10).
- Hits aimed at the victim, at the next victim, and at the two unmarked ways. These tell apart the three hit outcomes.

A long pseudo-random mix then runs against a behavioural model. The model includes its own LFSR written as integer arithmetic. The mix checks that both the chosen candidate and the running LFSR phase match on every clock.

// File: rtl/vnv_pkg.sv
package vnv_pkg;
  localparam int NUM_WAYS = 4;
  localparam int IDX_W    = $clog2(NUM_WAYS);

  typedef logic [NUM_WAYS-1:0] way_mask_t;
  typedef logic [IDX_W-1:0]    way_idx_t;

  // index of the set bit of a one-hot mask (0 if empty)
  function automatic way_idx_t mask_to_idx(input way_mask_t m);
    way_idx_t r;
    r = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (m[i]) r = r | way_idx_t'(i);
    return r;
  endfunction

  function automatic way_mask_t idx_to_mask(input way_idx_t w);
    return way_mask_t'(1) << w;
  endfunction

  // choose lowest (sel=0) or highest (sel=1) set bit of the free mask
  function automatic way_mask_t pick_free(input way_mask_t free_m, input logic sel);
    way_mask_t lo, hi;
    lo = '0;
    hi = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (free_m[i]) lo = idx_to_mask(way_idx_t'(i));
    for (int i = 0; i < NUM_WAYS; i++)
      if (free_m[i]) hi = idx_to_mask(way_idx_t'(i));
    return sel ? hi : lo;
  endfunction
endpackage

// File: rtl/vnv_lfsr.sv
module vnv_lfsr #(
  parameter int          W     = 8,
  parameter logic [W-1:0] SEED = 8'hA5,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter int          OUT_BIT = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic rnd_bit
);
  logic [W-1:0] state;
  logic         feedback;

  assign feedback = ^(state & TAPS);
  assign rnd_bit  = state[OUT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], feedback};
  end

  // R9: a maximal sequence from a nonzero seed never reaches zero
  p_lfsr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/vnv_next_state.sv
module vnv_next_state
  import vnv_pkg::*;
(
  input  way_mask_t cur_v,
  input  way_mask_t cur_n,
  input  logic      acc_valid,
  input  logic      acc_hit,
  input  way_idx_t  acc_way,
  input  logic      pick,
  output way_mask_t nxt_v,
  output way_mask_t nxt_n,
  output logic      evt_promote,
  output logic      evt_refresh
);
  way_mask_t hit_m, free_m;

  assign hit_m  = idx_to_mask(acc_way);
  assign free_m = ~(cur_v | cur_n);

  // miss, or hit on the victim: queue moves forward
  assign evt_promote = acc_valid && (!acc_hit || ((hit_m & cur_v) != '0));
  // hit on the next victim: only the queued slot is replaced
  assign evt_refresh = acc_valid && acc_hit && ((hit_m & cur_n) != '0);

  always_comb begin
    nxt_v = cur_v;
    nxt_n = cur_n;
    if (evt_promote) begin
      nxt_v = cur_n;
      nxt_n = pick_free(free_m, pick);
    end else if (evt_refresh) begin
      nxt_n = pick_free(free_m, pick);
    end
  end
endmodule

// File: rtl/vnv_repl_set.sv
module vnv_repl_set
  import vnv_pkg::*;
#(
  parameter logic [7:0] LFSR_SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_hit,
  input  logic [1:0] acc_way,
  output logic [1:0] victim_way,
  output logic [1:0] next_way
);
  way_mask_t role_v, role_n, nxt_v, nxt_n;
  logic      pick, evt_promote, evt_refresh;

  vnv_lfsr #(.W(8), .SEED(LFSR_SEED), .TAPS(8'hB8), .OUT_BIT(0)) u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .rnd_bit (pick)
  );

  vnv_next_state u_ns (
    .cur_v       (role_v),
    .cur_n       (role_n),
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .acc_way     (acc_way),
    .pick        (pick),
    .nxt_v       (nxt_v),
    .nxt_n       (nxt_n),
    .evt_promote (evt_promote),
    .evt_refresh (evt_refresh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_v <= idx_to_mask(way_idx_t'(0));
      role_n <= idx_to_mask(way_idx_t'(1));
    end else begin
      role_v <= nxt_v;
      role_n <= nxt_n;
    end
  end

  assign victim_way = mask_to_idx(role_v);
  assign next_way   = mask_to_idx(role_n);

  p_roles_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(role_v) == 1 && $countones(role_n) == 1 && (role_v & role_n) == '0);

  p_promote_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_promote |=> victim_way == $past(next_way));

  p_promote_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_promote |=> next_way != $past(victim_way) && next_way != $past(next_way));

  p_refresh_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_refresh |=> victim_way == $past(victim_way) && next_way != $past(next_way));

  // R7 / R8: no qualifying event leaves both roles in place
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_promote || evt_refresh) |=> $stable(victim_way) && $stable(next_way));

  p_idle_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !evt_promote && !evt_refresh);
endmodule

// File: tb/sim_vnv_repl_set.sv
module sim_vnv_repl_set;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_hit;
  logic [1:0] acc_way;
  logic [1:0] victim_way, next_way;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  int mv, mnv, ml;
  string cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vnv_repl_set u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .victim_way(victim_way), .next_way(next_way)
  );

  function automatic int lfsr_step(int s);
    int fb;
    fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
    return ((s << 1) | fb) & 255;
  endfunction

  function automatic int choose(int v, int n, int bitv);
    int q[$];
    for (int w = 0; w < 4; w++)
      if (w != v && w != n) q.push_back(w);
    return q[bitv];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv = 0; mnv = 1; ml = 8'hA5;
    end else begin
      if (acc_valid) begin
        if (!acc_hit || int'(acc_way) == mv) begin
          int nn;
          nn  = choose(mv, mnv, ml & 1);
          mv  = mnv;
          mnv = nn;
        end else if (int'(acc_way) == mnv) begin
          mnv = choose(mv, mnv, ml & 1);
        end
      end
      ml = lfsr_step(ml);
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(cur_tag, int'(victim_way), mv, "victim_way");
    check(cur_tag, int'(next_way), mnv, "next_way");
  endtask

  task automatic step(bit v, bit h, int w, string tag);
    acc_valid = v; acc_hit = h; acc_way = 2'(w);
    cur_tag = tag;
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_hit = 0; acc_way = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(victim_way), 0, "reset victim");
    check("R1", int'(next_way), 1, "reset next");
    rst_n = 1'b1;
    // R8: idle with junk hit/way
    for (int i = 0; i < 6; i++) step(0, i[0], i % 4, "R8");
    // R10 / R4: misses with assorted way values
    for (int i = 0; i < 8; i++) step(1, 0, (i * 3) % 4, i[0] ? "R10" : "R4");
    // R5: hits on the current victim
    for (int i = 0; i < 6; i++) step(1, 1, mv, "R5");
    // R6: hits on the next victim
    for (int i = 0; i < 6; i++) step(1, 1, mnv, "R6");
    // R7: hits on unmarked ways
    for (int i = 0; i < 6; i++) step(1, 1, choose(mv, mnv, i & 1), "R7");
    // R9 / R3 / R2: long mixed run checks the tie-break phase every cycle
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 4, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule